// File: doc/BRIEF.md
# Synchronous Buck Gate Sequencer

This block converts a per-period on-time request into two gate commands for a synchronous step-down power stage: `hdrv` for the high-side switch and `ldrv` for the low-side switch. A separate switching-period counter supplies a one-clock `cycle_start` pulse at the start of every period. The duty word is an on-time in clocks, and the block samples it on that pulse. The high-side on-time is capped at a ceiling below 100% of the period, and a duty word of zero is allowed.

The two commands never overlap. There is a gap on each transition. Before `hdrv` rises, the sequencer drops `ldrv` and waits a short fixed gap. After `hdrv` falls, it waits for the switch node to be sensed low (`sw_low`) before raising `ldrv`. A timeout keeps the sequence from stalling if that sense never arrives. A low `enable` or a high `fault` forces both commands low. A parameter selects the slow or fast switching variant; the period in clocks follows from the clock rate.

Top module: `buck_gate_seq`

## Requirements
- R1: After reset, both `hdrv` and `ldrv` are low, and they stay low until a `cycle_start` pulse is accepted.
- R2: The period is CLK_KHZ/300 clocks, or CLK_KHZ/600 clocks when FAST is set: 833 or 416 clocks at 250 MHz. The ceiling is floor(period*93/100): 774 or 386 clocks. `hdrv` is never high once the count of clocks since the `cycle_start` edge reaches the ceiling.
- R3: When the duty word is 0 on a `cycle_start` pulse, `hdrv` stays low for the whole period. `ldrv` is high from that same edge.
- R4: When the duty word is nonzero on a `cycle_start` pulse, both outputs are low for LH_DEAD clocks (default 2). `hdrv` is then high for the effective on-time. `hdrv` never rises in the clock right after a clock in which `ldrv` was high.
- R5: After `hdrv` falls, `ldrv` rises on the first clock edge that samples `sw_low` high. `ldrv` never rises in the clock right after a clock in which `hdrv` was high.
- R6: If `sw_low` stays low, `ldrv` rises HL_TMO clocks (default 10) after `hdrv` falls.
- R7: While `fault` is high, both outputs are low from the next edge onward. After `fault` clears, they stay low until the next `cycle_start`.
- R8: While `enable` is low, both outputs are low, the period count is held at zero, and `cycle_start` pulses have no effect.
- R9: A duty word above the ceiling is clamped to the ceiling, not wrapped. The effective on-time is min(duty, ceiling - LH_DEAD).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run permission; low forces both gates off |
| fault | input | 1 | Latched fault level; high forces both gates off |
| cycle_start | input | 1 | One-clock pulse at the start of each switching period |
| duty | input | DUTY_W | Requested high-side on-time in clocks, sampled on `cycle_start` |
| sw_low | input | 1 | Switch node sensed low |
| hdrv | output | 1 | High-side gate command |
| ldrv | output | 1 | Low-side gate command |

## Verification
Call the `cycle_start` edge edge 0. The outputs are decoded from one registered state, so `hdrv` is first seen high after edge 2. It stays high for D sample points and is low again after edge 2+D. The low-side command follows one edge after `sw_low` is sampled high, or after edge 12+D when the sense is withheld. Fault and enable take effect at the next edge. Each scenario task samples at falling clock edges, indexed from the first falling edge after edge 0. It compares the first and last high index and the high count of each command with these figures, and it flags any sample with both commands high.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;
  typedef enum logic [2:0] {
    GS_IDLE   = 3'd0,
    GS_LOW    = 3'd1,
    GS_GAP_LH = 3'd2,
    GS_HIGH   = 3'd3,
    GS_GAP_HL = 3'd4
  } gate_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/buck_period_timer.sv
module buck_period_timer #(
  parameter int unsigned PERIOD = 833,
  parameter int unsigned CEIL   = 774,
  parameter int unsigned DUTY_W = 10,
  parameter int unsigned PH_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cycle_start,
  input  logic [DUTY_W-1:0] duty,
  output logic [PH_W-1:0]   phase,
  output logic [DUTY_W-1:0] duty_eff,
  output logic [DUTY_W-1:0] duty_lat
);
  localparam logic [PH_W-1:0]   PH_LAST  = PH_W'(PERIOD - 1);
  localparam logic [DUTY_W-1:0] CEIL_VAL = DUTY_W'(CEIL);

  // clamp the request, never wrap it
  always_comb duty_eff = (duty > CEIL_VAL) ? CEIL_VAL : duty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= '0;
      duty_lat <= '0;
    end else if (!enable) begin
      phase    <= '0;
    end else if (cycle_start) begin
      phase    <= '0;
      duty_lat <= duty_eff;
    end else if (phase != PH_LAST) begin
      phase    <= phase + 1'b1;
    end
  end

  assert_clamp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(enable && cycle_start) |-> (duty_lat <= CEIL_VAL));
endmodule

// File: rtl/buck_gate_fsm.sv
module buck_gate_fsm
  import buck_seq_pkg::*;
#(
  parameter int unsigned CEIL    = 774,
  parameter int unsigned DUTY_W  = 10,
  parameter int unsigned PH_W    = 10,
  parameter int unsigned LH_DEAD = 2,
  parameter int unsigned HL_TMO  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              cycle_start,
  input  logic [DUTY_W-1:0] duty_eff,
  input  logic [DUTY_W-1:0] duty_lat,
  input  logic [PH_W-1:0]   phase,
  input  logic              sw_low,
  output logic              hdrv,
  output logic              ldrv
);
  localparam int unsigned CNT_W = $clog2(max2(LH_DEAD, HL_TMO) + 1);
  localparam logic [CNT_W-1:0] LH_END  = CNT_W'(LH_DEAD - 1);
  localparam logic [CNT_W-1:0] HL_END  = CNT_W'(HL_TMO - 1);
  localparam logic [PH_W:0]    CEIL_PH = (PH_W+1)'(CEIL);

  gate_state_e       state;
  logic [CNT_W-1:0]  gap_cnt;
  logic [DUTY_W-1:0] on_cnt;
  logic [PH_W:0]     ph_inc;
  logic              at_ceiling, on_done;

  always_comb begin
    ph_inc     = {1'b0, phase} + 1'b1;
    at_ceiling = (ph_inc >= CEIL_PH);
    on_done    = (on_cnt == duty_lat - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= GS_IDLE;
      gap_cnt <= '0;
      on_cnt  <= '0;
    end else if (!run) begin
      state   <= GS_IDLE;
      gap_cnt <= '0;
      on_cnt  <= '0;
    end else begin
      case (state)
        GS_IDLE, GS_LOW: begin
          if (cycle_start) begin
            gap_cnt <= '0;
            state   <= (duty_eff == '0) ? GS_LOW : GS_GAP_LH;
          end
        end
        GS_GAP_LH: begin
          if (cycle_start) begin
            gap_cnt <= '0;
            state   <= (duty_eff == '0) ? GS_LOW : GS_GAP_LH;
          end else if (at_ceiling) begin
            state   <= GS_LOW;
          end else if (gap_cnt == LH_END) begin
            on_cnt  <= '0;
            state   <= GS_HIGH;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        GS_HIGH: begin
          if (cycle_start || on_done || at_ceiling) begin
            gap_cnt <= '0;
            state   <= GS_GAP_HL;
          end else begin
            on_cnt  <= on_cnt + 1'b1;
          end
        end
        GS_GAP_HL: begin
          if (sw_low || gap_cnt == HL_END) state <= GS_LOW;
          else gap_cnt <= gap_cnt + 1'b1;
        end
        default: state <= GS_IDLE;
      endcase
    end
  end

  always_comb begin
    hdrv = (state == GS_HIGH);
    ldrv = (state == GS_LOW);
  end

  assert_lh_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hdrv) |-> !$past(ldrv));
  assert_hl_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ldrv) |-> !$past(hdrv));
  assert_ceiling_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hdrv |-> ({1'b0, phase} < CEIL_PH));
  assert_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GS_GAP_HL) |-> (gap_cnt <= HL_END));
endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq #(
  parameter int unsigned CLK_KHZ = 250000,
  parameter bit          FAST    = 1'b0,
  parameter int unsigned DUTY_W  = 10,
  parameter int unsigned LH_DEAD = 2,
  parameter int unsigned HL_TMO  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              fault,
  input  logic              cycle_start,
  input  logic [DUTY_W-1:0] duty,
  input  logic              sw_low,
  output logic              hdrv,
  output logic              ldrv
);
  localparam int unsigned PERIOD = CLK_KHZ / (FAST ? 600 : 300);
  localparam int unsigned CEIL   = (PERIOD * 93) / 100;
  localparam int unsigned PH_W   = $clog2(PERIOD);

  logic [PH_W-1:0]   phase;
  logic [DUTY_W-1:0] duty_eff, duty_lat;
  logic              run;

  always_comb run = enable && !fault;

  buck_period_timer #(
    .PERIOD(PERIOD), .CEIL(CEIL), .DUTY_W(DUTY_W), .PH_W(PH_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cycle_start(cycle_start),
    .duty(duty), .phase(phase), .duty_eff(duty_eff), .duty_lat(duty_lat)
  );

  buck_gate_fsm #(
    .CEIL(CEIL), .DUTY_W(DUTY_W), .PH_W(PH_W),
    .LH_DEAD(LH_DEAD), .HL_TMO(HL_TMO)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .run(run), .cycle_start(cycle_start),
    .duty_eff(duty_eff), .duty_lat(duty_lat), .phase(phase),
    .sw_low(sw_low), .hdrv(hdrv), .ldrv(ldrv)
  );

  assert_fault_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!hdrv && !ldrv));
  assert_enable_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!hdrv && !ldrv && phase == '0));
endmodule

// File: tb/buck_gate_seq_test.sv
`timescale 1ns/1ps
module buck_gate_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, fault = 1'b0, cycle_start = 1'b0, sw_low = 1'b0;
  logic [9:0] duty = '0;
  logic hdrv, ldrv, hdrv_f, ldrv_f;

  int checks = 0, errors = 0;
  int first_h, last_h, h_cnt, h_cnt_f, first_l, l0;
  bit overlap, done = 0;

  always #2 clk = ~clk;

  buck_gate_seq uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fault(fault),
    .cycle_start(cycle_start), .duty(duty), .sw_low(sw_low),
    .hdrv(hdrv), .ldrv(ldrv)
  );
  buck_gate_seq #(.FAST(1'b1)) uut_fast (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fault(fault),
    .cycle_start(cycle_start), .duty(duty), .sw_low(sw_low),
    .hdrv(hdrv_f), .ldrv(ldrv_f)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode 0: sw_low held low, 1: held high, 2: raised at index d+4
  task automatic run_window(input int d, input int mode, input int n);
    first_h = -1; last_h = -1; h_cnt = 0; h_cnt_f = 0; first_l = -1; overlap = 0;
    @(negedge clk); duty = 10'(d); cycle_start = 1'b1; sw_low = (mode == 1);
    @(negedge clk); cycle_start = 1'b0;
    l0 = ldrv;
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      if (hdrv) begin h_cnt++; if (first_h < 0) first_h = i; last_h = i; end
      if (hdrv_f) h_cnt_f++;
      if (ldrv && last_h >= 0 && first_l < 0) first_l = i;
      if ((hdrv && ldrv) || (hdrv_f && ldrv_f)) overlap = 1;
      if (mode == 2 && i == d + 4) sw_low = 1'b1;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!hdrv && !ldrv, "R1 reset outputs", {hdrv, ldrv}, 0);
    rst_n = 1'b1; enable = 1'b1;
    repeat (5) @(negedge clk);
    check(!hdrv && !ldrv, "R1 idle before cycle_start", {hdrv, ldrv}, 0);
  endtask

  task automatic t_prompt();
    run_window(20, 1, 40);
    check(first_h == 2, "R4 hdrv rise index", first_h, 2);
    check(h_cnt == 20, "R4 on-time", h_cnt, 20);
    check(first_l == 23, "R5 prompt ldrv index", first_l, 23);
    check(!overlap, "R4 no overlap", overlap, 0);
  endtask

  task automatic t_timeout();
    run_window(5, 0, 30);
    check(h_cnt == 5, "R6 on-time", h_cnt, 5);
    check(first_l == 17, "R6 timeout ldrv index", first_l, 17);
  endtask

  task automatic t_late_sense();
    run_window(8, 2, 30);
    check(first_l == 13, "R5 late sense ldrv index", first_l, 13);
    check(!overlap, "R5 no overlap", overlap, 0);
  endtask

  task automatic t_ceiling();
    run_window(1000, 1, 800);
    check(h_cnt == 772, "R9 clamped on-time slow", h_cnt, 772);
    check(last_h == 773, "R2 last high index slow", last_h, 773);
    check(h_cnt_f == 384, "R2 clamped on-time fast", h_cnt_f, 384);
    check(!overlap, "R2 no overlap", overlap, 0);
  endtask

  task automatic t_fault();
    @(negedge clk); duty = 10'd50; cycle_start = 1'b1; sw_low = 1'b1;
    @(negedge clk); cycle_start = 1'b0;
    repeat (9) @(negedge clk);
    check(hdrv, "R7 hdrv high before fault", hdrv, 1);
    fault = 1'b1;
    @(negedge clk);
    check(!hdrv && !ldrv, "R7 off after fault", {hdrv, ldrv}, 0);
    cycle_start = 1'b1;
    @(negedge clk); cycle_start = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!hdrv && !ldrv, "R7 held off", {hdrv, ldrv}, 0);
    end
    fault = 1'b0;
    repeat (3) @(negedge clk);
    check(!hdrv && !ldrv, "R7 idle after release", {hdrv, ldrv}, 0);
    run_window(6, 1, 20);
    check(first_h == 2 && h_cnt == 6, "R7 resumes", h_cnt, 6);
  endtask

  task automatic t_enable();
    @(negedge clk); enable = 1'b0;
    @(negedge clk); duty = 10'd30; cycle_start = 1'b1;
    @(negedge clk); cycle_start = 1'b0;
    h_cnt = 0; first_l = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (hdrv || hdrv_f) h_cnt++;
      if (ldrv || ldrv_f) first_l++;
    end
    check(h_cnt == 0, "R8 hdrv off while disabled", h_cnt, 0);
    check(first_l == 0, "R8 ldrv off while disabled", first_l, 0);
    enable = 1'b1;
  endtask

  task automatic t_zero();
    run_window(0, 1, 60);
    check(l0 == 1, "R3 ldrv on at start", l0, 1);
    check(h_cnt == 0 && h_cnt_f == 0, "R3 no hdrv", h_cnt, 0);
  endtask

  initial begin
    t_reset();
    t_prompt();
    t_timeout();
    t_late_sense();
    t_ceiling();
    t_fault();
    t_enable();
    t_zero();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule